// File: doc/BRIEF.md
# Model-Specific Register Access Unit

This block serves privileged read and write requests aimed at a sparse space of 64-bit model-specific registers, each selected by a 32-bit index. Every request carries a 2-bit privilege level. A request is accepted only when its index falls inside the populated map and its privilege level is 0. Any other request completes with a general-protection fault, whose error code is always zero, and changes nothing.

Inside the block sit a read-only machine-check address register, a read-only machine-check attribute register whose check flag clears when it is read, a trace-control register with four control bits, and a bank of plain 64-bit storage used for cache, TLB and branch-buffer testing. The four counter indices are not stored here. Accesses to them are passed to external counter logic through a forwarding port, and a read returns whatever that logic presents in the request cycle.

A requester presents one request for one cycle. The response (done, fault and the 64-bit read data split into high and low halves) appears on the next cycle and lasts exactly one cycle. Machine-check events are captured from a separate strobe carrying the address and the bus-cycle attributes.

Top module: `msr_access_unit`

## Requirements
- R1: Accepted indices are 0, 1, 2, 4 to 14 and 16 to 19, compared over all 32 bits. Index 3, index 15, any index of 20 or more, and any index with upper bits set complete with a fault.
- R2: A request with a nonzero privilege level completes with a fault. It changes no register, does not clear the check flag, and does not assert the forwarding strobe.
- R3: A request on `req_valid` in one cycle gives `rsp_done` high for exactly the next cycle, with `rsp_fault` telling the outcome. A cycle without a request gives no `rsp_done`. The fault error code is 0, and a faulted or write response returns zero data.
- R4: Index 0 reads the captured 32-bit machine-check address in bits 31..0 and zero in bits 63..32. A write to it completes without fault and has no effect.
- R5: Index 1 reads the captured attributes: bit 4 lock, bit 3 memory/IO, bit 2 data/code, bit 1 write/read, and bit 0 the check flag. Bits 63..5 read zero. A write to it completes without fault and has no effect.
- R6: The check flag is set by a machine-check event and is cleared by an accepted read of index 1, which still returns it as 1. If an event arrives in the same cycle as that read, the read returns the old value and the flag stays set.
- R7: Index 14 holds four read/write control bits in bits 3..0, and bits 63..4 read zero. Bit 1 drives `trace_en`, and bits 3..0 appear on `trace_ctl`.
- R8: Indices 2 and 4 to 13 are plain 64-bit read/write storage.
- R9: An accepted access to indices 16 to 19 asserts `fwd_valid` in the same cycle, with `fwd_sel` equal to index bits 1..0, plus `fwd_write` and `fwd_wdata`. A read returns the `fwd_rdata` present in the request cycle.
- R10: After reset every register reads zero, `trace_en` is low and `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_priv | input | 2 | Privilege level of the requester |
| req_wdata_hi | input | 32 | Write data bits 63..32 |
| req_wdata_lo | input | 32 | Write data bits 31..0 |
| rsp_done | output | 1 | Completion, one cycle after the request |
| rsp_fault | output | 1 | General-protection fault, valid with done |
| rsp_err_code | output | 16 | Fault error code (always 0) |
| rsp_rdata_hi | output | 32 | Read data bits 63..32 |
| rsp_rdata_lo | output | 32 | Read data bits 31..0 |
| mc_event | input | 1 | Machine-check capture strobe |
| mc_addr | input | 32 | Physical address at the event |
| mc_lock | input | 1 | Locked bus cycle at the event |
| mc_mem_io | input | 1 | Memory/IO attribute at the event |
| mc_data_code | input | 1 | Data/code attribute at the event |
| mc_wr_rd | input | 1 | Write/read attribute at the event |
| trace_en | output | 1 | Branch-trace message cycle enable |
| trace_ctl | output | 4 | Trace-control register bits 3..0 |
| fwd_valid | output | 1 | Counter access strobe |
| fwd_write | output | 1 | Counter access is a write |
| fwd_sel | output | 2 | Counter selected (index bits 1..0) |
| fwd_wdata | output | 64 | Counter write data |
| fwd_rdata | input | 64 | Counter read data |

## Verification
The bench builds the block with its default parameters: a 32-bit index, 32-bit data halves and a 2-bit privilege level. With these values the full index width is reachable. Random indices above 19 and indices with high bits set exercise the upper-bit compare, while dense draws over 0 to 20 hit both reserved holes and every populated slot. Every privilege level is reachable, so faulted writes and faulted reads of the check flag can be interleaved with machine-check events landing on the same cycle as a read.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic [2:0] {
    K_MCADDR = 3'd0,
    K_MCTYPE = 3'd1,
    K_STORE  = 3'd2,
    K_CTR    = 3'd3,
    K_BAD    = 3'd4
  } msr_kind_e;

  localparam int unsigned IDX_MCADDR = 0;
  localparam int unsigned IDX_MCTYPE = 1;
  localparam int unsigned IDX_HOLE_A = 3;
  localparam int unsigned IDX_TRCTL  = 14;
  localparam int unsigned IDX_HOLE_B = 15;
  localparam int unsigned IDX_CTR_LO = 16;
  localparam int unsigned IDX_CTR_HI = 19;

  localparam int unsigned TRCTL_W    = 4;
  localparam int unsigned TRACE_BIT  = 1;
  localparam int unsigned MCT_W      = 5;
  localparam int unsigned CTR_SEL_W  = 2;
  localparam int unsigned ERR_W      = 16;
  localparam logic [ERR_W-1:0] GP_ERR_CODE = '0;

  function automatic bit is_store_slot(input int unsigned s);
    return (s == 2) || ((s >= 4) && (s <= IDX_TRCTL));
  endfunction

endpackage

// File: rtl/msr_index_decode.sv
module msr_index_decode
  import msr_pkg::*;
#(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned SLOT_W = 4
) (
  input  logic [IDX_W-1:0]     idx,
  output msr_kind_e            kind,
  output logic [SLOT_W-1:0]    slot,
  output logic [CTR_SEL_W-1:0] ctr_sel
);

  localparam logic [IDX_W-1:0] K_ADDR  = IDX_W'(IDX_MCADDR);
  localparam logic [IDX_W-1:0] K_TYPE  = IDX_W'(IDX_MCTYPE);
  localparam logic [IDX_W-1:0] K_HOLE  = IDX_W'(IDX_HOLE_A);
  localparam logic [IDX_W-1:0] K_STTOP = IDX_W'(IDX_TRCTL);
  localparam logic [IDX_W-1:0] K_CLO   = IDX_W'(IDX_CTR_LO);
  localparam logic [IDX_W-1:0] K_CHI   = IDX_W'(IDX_CTR_HI);

  always_comb begin
    if (idx == K_ADDR)                      kind = K_MCADDR;
    else if (idx == K_TYPE)                 kind = K_MCTYPE;
    else if (idx <= K_STTOP && idx != K_HOLE) kind = K_STORE;
    else if (idx >= K_CLO && idx <= K_CHI)  kind = K_CTR;
    else                                    kind = K_BAD;
  end

  assign slot    = idx[SLOT_W-1:0];
  assign ctr_sel = idx[CTR_SEL_W-1:0];

endmodule

// File: rtl/msr_mc_regs.sv
module msr_mc_regs
  import msr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_event,
  input  logic [ADDR_W-1:0] mc_addr,
  input  logic [MCT_W-2:0]  mc_attr,
  input  logic              chk_clr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [MCT_W-1:0]  type_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [MCT_W-2:0]  attr_q, attr_d;
  logic              chk_q, chk_d;

  always_comb begin
    addr_d = addr_q;
    attr_d = attr_q;
    chk_d  = chk_q;
    if (chk_clr) chk_d = 1'b0;
    if (mc_event) begin
      addr_d = mc_addr;
      attr_d = mc_attr;
      chk_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      attr_q <= '0;
      chk_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      attr_q <= attr_d;
      chk_q  <= chk_d;
    end
  end

  assign type_q = {attr_q, chk_q};

  AST_CHK_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    mc_event |=> chk_q); // R6
  AST_CHK_CLR_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_clr && !mc_event) |=> !chk_q); // R6
  AST_ADDR_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_event |=> $stable(addr_q)); // R4

endmodule

// File: rtl/msr_store.sv
module msr_store
  import msr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SLOT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [DATA_W-1:0]  rdata,
  output logic [TRCTL_W-1:0] trctl
);

  localparam int unsigned NSLOT = 1 << SLOT_W;

  logic [DATA_W-1:0] slot_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == IDX_TRCTL) begin : g_ctl
      logic [TRCTL_W-1:0] q, d;
      always_comb d = (wr_en && wr_slot == SLOT_W'(s)) ? wdata[TRCTL_W-1:0] : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign slot_q[s] = {{(DATA_W-TRCTL_W){1'b0}}, q};
    end else if (is_store_slot(s)) begin : g_reg
      logic [DATA_W-1:0] q, d;
      always_comb d = (wr_en && wr_slot == SLOT_W'(s)) ? wdata : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign slot_q[s] = q;
    end else begin : g_none
      assign slot_q[s] = '0;
    end
  end

  assign rdata = slot_q[rd_slot];
  assign trctl = slot_q[IDX_TRCTL][TRCTL_W-1:0];

  AST_TRCTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(trctl)); // R7

endmodule

// File: rtl/msr_access_unit.sv
module msr_access_unit
  import msr_pkg::*;
#(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned PRIV_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [IDX_W-1:0]     req_index,
  input  logic [PRIV_W-1:0]    req_priv,
  input  logic [HALF_W-1:0]    req_wdata_hi,
  input  logic [HALF_W-1:0]    req_wdata_lo,
  output logic                 rsp_done,
  output logic                 rsp_fault,
  output logic [ERR_W-1:0]     rsp_err_code,
  output logic [HALF_W-1:0]    rsp_rdata_hi,
  output logic [HALF_W-1:0]    rsp_rdata_lo,
  input  logic                 mc_event,
  input  logic [HALF_W-1:0]    mc_addr,
  input  logic                 mc_lock,
  input  logic                 mc_mem_io,
  input  logic                 mc_data_code,
  input  logic                 mc_wr_rd,
  output logic                 trace_en,
  output logic [TRCTL_W-1:0]   trace_ctl,
  output logic                 fwd_valid,
  output logic                 fwd_write,
  output logic [CTR_SEL_W-1:0] fwd_sel,
  output logic [2*HALF_W-1:0]  fwd_wdata,
  input  logic [2*HALF_W-1:0]  fwd_rdata
);

  localparam int unsigned DATA_W = 2 * HALF_W;
  localparam int unsigned SLOT_W = 4;

  msr_kind_e            kind;
  logic [SLOT_W-1:0]    slot;
  logic [CTR_SEL_W-1:0] ctr_sel;
  logic                 acc_ok;
  logic [DATA_W-1:0]    wdata;
  logic [DATA_W-1:0]    store_rdata;
  logic [HALF_W-1:0]    mc_addr_q;
  logic [MCT_W-1:0]     mc_type_q;
  logic [DATA_W-1:0]    rd_mux;

  logic                 done_q, done_d;
  logic                 fault_q, fault_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;

  assign wdata = {req_wdata_hi, req_wdata_lo};

  msr_index_decode #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_dec (
    .idx     (req_index),
    .kind    (kind),
    .slot    (slot),
    .ctr_sel (ctr_sel)
  );

  assign acc_ok = req_valid && (req_priv == '0) && (kind != K_BAD);

  msr_mc_regs #(.ADDR_W(HALF_W)) u_mc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_event (mc_event),
    .mc_addr  (mc_addr),
    .mc_attr  ({mc_lock, mc_mem_io, mc_data_code, mc_wr_rd}),
    .chk_clr  (acc_ok && !req_write && kind == K_MCTYPE),
    .addr_q   (mc_addr_q),
    .type_q   (mc_type_q)
  );

  msr_store #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_ok && req_write && kind == K_STORE),
    .wr_slot (slot),
    .wdata   (wdata),
    .rd_slot (slot),
    .rdata   (store_rdata),
    .trctl   (trace_ctl)
  );

  assign trace_en  = trace_ctl[TRACE_BIT];
  assign fwd_valid = acc_ok && kind == K_CTR;
  assign fwd_write = req_write;
  assign fwd_sel   = ctr_sel;
  assign fwd_wdata = wdata;

  always_comb begin
    case (kind)
      K_MCADDR: rd_mux = {{(DATA_W-HALF_W){1'b0}}, mc_addr_q};
      K_MCTYPE: rd_mux = {{(DATA_W-MCT_W){1'b0}}, mc_type_q};
      K_STORE:  rd_mux = store_rdata;
      K_CTR:    rd_mux = fwd_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    done_d  = req_valid;
    fault_d = req_valid && !acc_ok;
    rdata_d = (acc_ok && !req_write) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= done_d;
      fault_q <= fault_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_done     = done_q;
  assign rsp_fault    = fault_q;
  assign rsp_err_code = GP_ERR_CODE;
  assign rsp_rdata_hi = rdata_q[DATA_W-1:HALF_W];
  assign rsp_rdata_lo = rdata_q[HALF_W-1:0];

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done); // R3
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done); // R3
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_rdata_hi == '0 && rsp_rdata_lo == '0 && rsp_done)); // R3
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv != '0) |=> rsp_fault); // R2
  AST_NO_FWD_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (req_valid && req_priv == '0)); // R2
  AST_HOLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_index == IDX_W'(IDX_HOLE_A) ||
                   req_index == IDX_W'(IDX_HOLE_B))) |=> rsp_fault); // R1

endmodule

// File: tb/test_msr_access_unit.sv
module test_msr_access_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_index;
  logic [1:0]  req_priv;
  logic [31:0] req_wdata_hi, req_wdata_lo;
  logic        rsp_done, rsp_fault;
  logic [15:0] rsp_err_code;
  logic [31:0] rsp_rdata_hi, rsp_rdata_lo;
  logic        mc_event;
  logic [31:0] mc_addr;
  logic        mc_lock, mc_mem_io, mc_data_code, mc_wr_rd;
  logic        trace_en;
  logic [3:0]  trace_ctl;
  logic        fwd_valid, fwd_write;
  logic [1:0]  fwd_sel;
  logic [63:0] fwd_wdata, fwd_rdata;

  always #4 clk = ~clk;

  msr_access_unit i_msr_access_unit (
    .clk, .rst_n, .req_valid, .req_write, .req_index, .req_priv,
    .req_wdata_hi, .req_wdata_lo, .rsp_done, .rsp_fault, .rsp_err_code,
    .rsp_rdata_hi, .rsp_rdata_lo, .mc_event, .mc_addr, .mc_lock,
    .mc_mem_io, .mc_data_code, .mc_wr_rd, .trace_en, .trace_ctl,
    .fwd_valid, .fwd_write, .fwd_sel, .fwd_wdata, .fwd_rdata
  );

  function automatic logic [63:0] ext_pat(input logic [1:0] s);
    return {32'hE000_0000 | {30'd0, s}, 32'h0000_C000 | {30'd0, s}};
  endfunction

  assign fwd_rdata = ext_pat(fwd_sel);

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] m_addr;
  logic [4:0]  m_attr;
  logic [63:0] m_store [16];

  function automatic bit idx_ok(input logic [31:0] i);
    return (i <= 32'd14 && i != 32'd3) || (i >= 32'd16 && i <= 32'd19);
  endfunction

  function automatic logic [63:0] model_read(input logic [31:0] i);
    if (i == 32'd0) return {32'd0, m_addr};
    if (i == 32'd1) return {59'd0, m_attr};
    if (i >= 32'd16) return ext_pat(i[1:0]);
    if (i == 32'd14) return {60'd0, m_store[14][3:0]};
    return m_store[i[3:0]];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit v, input bit w, input logic [31:0] idx,
                    input logic [1:0] pr, input logic [63:0] wd, input bit mce,
                    input logic [31:0] ma, input logic [3:0] mat, input string tag);
    bit ok, exp_fault, exp_fwd;
    logic [63:0] exp_data;
    ok        = v && pr == 2'd0 && idx_ok(idx);
    exp_fault = v && !ok;
    exp_data  = (ok && !w) ? model_read(idx) : 64'd0;
    exp_fwd   = ok && idx >= 32'd16;
    req_valid = v; req_write = w; req_index = idx; req_priv = pr;
    {req_wdata_hi, req_wdata_lo} = wd;
    mc_event = mce; mc_addr = ma;
    {mc_lock, mc_mem_io, mc_data_code, mc_wr_rd} = mat;
    #1;
    chk(fwd_valid == exp_fwd && (!exp_fwd ||
        (fwd_sel == idx[1:0] && fwd_write == w && fwd_wdata == wd)),
        {tag, " R9 forward"}, {fwd_valid, fwd_sel, fwd_write}, {exp_fwd, idx[1:0], w});
    @(posedge clk);
    if (ok && w && idx <= 32'd14 && idx >= 32'd2)
      m_store[idx[3:0]] = (idx == 32'd14) ? {60'd0, wd[3:0]} : wd;
    if (ok && !w && idx == 32'd1) m_attr[0] = 1'b0;
    if (mce) begin m_addr = ma; m_attr = {mat, 1'b1}; end
    @(negedge clk);
    chk(rsp_done == v && rsp_fault == exp_fault && rsp_err_code == 16'd0,
        {tag, " R3 done/fault"}, {rsp_done, rsp_fault, rsp_err_code},
        {v, exp_fault, 16'd0});
    chk({rsp_rdata_hi, rsp_rdata_lo} == exp_data, {tag, " data"},
        {rsp_rdata_hi, rsp_rdata_lo}, exp_data);
    chk(trace_en == m_store[14][1] && trace_ctl == m_store[14][3:0],
        {tag, " R7 trace"}, {trace_en, trace_ctl}, {m_store[14][1], m_store[14][3:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_index = 0; req_priv = 0;
    req_wdata_hi = 0; req_wdata_lo = 0;
    mc_event = 0; mc_addr = 0; {mc_lock, mc_mem_io, mc_data_code, mc_wr_rd} = 4'd0;
    m_addr = 0; m_attr = 0;
    for (int k = 0; k < 16; k++) m_store[k] = 64'd0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_done == 0 && trace_en == 0, "R10 reset outputs", {rsp_done, trace_en}, 0);
    for (int k = 0; k < 15; k++)
      if (k != 3) op(1, 0, k, 0, 0, 0, 0, 0, "R10 reset read");

    op(1, 0, 32'd3, 0, 0, 0, 0, 0, "R1 hole 3");
    op(1, 1, 32'd15, 0, 64'h1, 0, 0, 0, "R1 hole 15");
    op(1, 0, 32'd20, 0, 0, 0, 0, 0, "R1 above top");
    op(1, 0, 32'h8000_0010, 0, 0, 0, 0, 0, "R1 upper bits");

    op(1, 1, 32'd2, 0, 64'hDEAD_BEEF_0123_4567, 0, 0, 0, "R8 write 2");
    op(1, 1, 32'd2, 2'd3, 64'h1111_2222_3333_4444, 0, 0, 0, "R2 priv write");
    op(1, 0, 32'd2, 0, 0, 0, 0, 0, "R2 unchanged read");
    op(1, 1, 32'd13, 0, 64'hFFFF_0000_AAAA_5555, 0, 0, 0, "R8 write 13");
    op(1, 0, 32'd13, 0, 0, 0, 0, 0, "R8 read 13");

    op(0, 0, 0, 0, 0, 1, 32'h0012_3450, 4'b1010, "R6 capture");
    op(1, 1, 32'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R4 write ro");
    op(1, 0, 32'd0, 0, 0, 0, 0, 0, "R4 read addr");
    op(1, 1, 32'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R5 write ro");
    op(1, 0, 32'd1, 2'd1, 0, 0, 0, 0, "R2 priv read of flag");
    op(1, 0, 32'd1, 0, 0, 0, 0, 0, "R5 R6 read sets");
    op(1, 0, 32'd1, 0, 0, 0, 0, 0, "R6 flag cleared");
    op(0, 0, 0, 0, 0, 1, 32'h0000_0AB0, 4'b0101, "R6 capture 2");
    op(1, 0, 32'd1, 0, 0, 1, 32'h0000_0CD0, 4'b1111, "R6 read with event");
    op(1, 0, 32'd1, 0, 0, 0, 0, 0, "R6 flag kept");

    op(1, 1, 32'd14, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R7 write all");
    op(1, 0, 32'd14, 0, 0, 0, 0, 0, "R7 read masked");
    op(1, 1, 32'd14, 0, 64'h0000_0000_0000_0002, 0, 0, 0, "R7 trace only");
    op(1, 1, 32'd14, 0, 64'd0, 0, 0, 0, "R7 clear");

    for (int k = 16; k < 20; k++) begin
      op(1, 0, k, 0, 0, 0, 0, 0, "R9 counter read");
      op(1, 1, k, 0, {32'hABCD_0000, 32'(k)}, 0, 0, 0, "R9 counter write");
    end
    op(1, 0, 32'd17, 2'd2, 0, 0, 0, 0, "R2 counter unpriv");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ri;
      logic [1:0]  rp;
      ri = ($urandom % 10 < 8) ? ($urandom % 21) : $urandom;
      rp = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd0;
      op(($urandom % 8) != 0, $urandom % 2, ri, rp, {$urandom, $urandom},
         ($urandom % 6) == 0, $urandom, 4'($urandom), "R1 R8 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule